// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block gives an 8-bit I/O bus access to a 256-byte configuration space through a window that is only two addresses wide. The lower address of the window holds a pointer register. The upper address is a data port that reads or writes the byte the pointer selects. The stored bytes set up peripheral functions elsewhere in the chip. This block holds only the bytes and the rules for changing them.

Most of the space is read-only. Reads still return the stored byte. Some scattered entries near the top of the space are also read-only. Two entries accept a write only when the written value equals one permitted byte. A separate host configuration write turns the whole window on or off. While the window is off, the bus sees no response from either address.

A read at the data port is answered one clock later with a one-cycle valid pulse. While that pulse is low, the read data bus sits at 0xFF.

Top module: `cfg_window_ctrl`

## Requirements
- R1: A write to the base address (default 0x3F0) loads the pointer with the written byte. No later access changes the pointer except another write to that address.
- R2: A read at base+1 (default 0x3F1) raises `io_rvalid` for exactly one cycle, in the cycle after the read strobe. In that cycle `io_rdata` carries the entry the pointer selects, for any pointer value. Whenever `io_rvalid` is low, `io_rdata` is 0xFF.
- R3: Data-port writes leave the entry unchanged when the pointer is 0x00 to 0xDF, 0xE4, 0xE5, 0xE9 to 0xED, 0xF3, 0xF5, 0xF7, 0xF9 to 0xFB, or 0xFD to 0xFF.
- R4: Entry 0xE7 accepts only the value 0xFE, and entry 0xE8 accepts only 0xBE. Any other written value leaves these entries unchanged.
- R5: After reset the entries hold 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Every other entry holds 0x00.
- R6: The window is off after reset. A host configuration write at offset 0x85 sets the window state from bit 1 of its data: 1 turns the window on, 0 turns it off. Host writes at any other offset leave the state unchanged.
- R7: While the window is off, writes to either address change neither the pointer nor any entry. Reads give no `io_rvalid` pulse, and `io_rdata` stays 0xFF.
- R8: Data-port writes always update entries 0xE0 to 0xE3, 0xE6, 0xEE to 0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R9: Accesses to addresses outside the two-byte window have no effect. A read at the base address gives no `io_rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rdata | output | 8 | Read data; 0xFF when not valid |
| io_rvalid | output | 1 | Read data valid pulse |
| host_cfg_we | input | 1 | Host configuration write strobe |
| host_cfg_off | input | 8 | Host configuration byte offset |
| host_cfg_wdata | input | 8 | Host configuration write data |

## Verification
The assertions take for granted that the read strobe and the write strobe are never high in the same cycle. They also take for granted that every strobe lasts one clock. Under these conditions the pointer and the stored entries change only when a write is decoded.

The bench drives each strobe for one cycle from the falling edge and never raises both strobes together. It turns the window on or off only with host writes at cycle boundaries that are separate from bus accesses.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int BYTE_W = 8;

    // Entries a data-port write may reach (value-locked ones included).
    function automatic logic entry_writable(input logic [7:0] idx);
        logic ok;
        ok = 1'b0;
        if (idx >= 8'hE0 && idx <= 8'hE3) ok = 1'b1;
        if (idx == 8'hE6 || idx == 8'hE7 || idx == 8'hE8) ok = 1'b1;
        if (idx >= 8'hEE && idx <= 8'hF2) ok = 1'b1;
        if (idx == 8'hF4 || idx == 8'hF6 || idx == 8'hF8 || idx == 8'hFC) ok = 1'b1;
        return ok;
    endfunction

    // Value gate for the two locked entries; everything else passes.
    function automatic logic value_permitted(input logic [7:0] idx, input logic [7:0] val);
        logic ok;
        case (idx)
            8'hE7:   ok = (val == 8'hFE);
            8'hE8:   ok = (val == 8'hBE);
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

    function automatic logic [7:0] entry_default(input logic [7:0] idx);
        logic [7:0] v;
        case (idx)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgw_decode.sv
module cfgw_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
    parameter logic [7:0]      EN_OFFSET = 8'h85,
    parameter int              EN_BIT    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              host_cfg_we,
    input  logic [7:0]        host_cfg_off,
    input  logic [7:0]        host_cfg_wdata,
    output logic              ptr_we,
    output logic              data_we,
    output logic              data_re,
    output logic              win_on
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    typedef struct packed {
        logic en;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    en_hit;

    always_comb begin
        st_d   = st_q;
        en_hit = host_cfg_we && (host_cfg_off == EN_OFFSET);
        if (en_hit) begin
            st_d.en = host_cfg_wdata[EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_on  = st_q.en;
    assign ptr_we  = st_q.en && io_wr && (io_addr == BASE_ADDR);
    assign data_we = st_q.en && io_wr && (io_addr == DATA_ADDR);
    assign data_re = st_q.en && io_rd && (io_addr == DATA_ADDR);

    p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_cfg_we && host_cfg_off == EN_OFFSET) |=> $stable(win_on));

    p_off_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_on |-> !(ptr_we || data_we || data_re));

endmodule

// File: rtl/cfgw_store.sv
module cfgw_store
    import cfgw_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    output logic              rvalid,
    output logic [BYTE_W-1:0] rdata
);

    localparam int N_ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [N_ENTRIES-1:0][BYTE_W-1:0] mem;
        logic [IDX_W-1:0]                 ptr;
        logic                             rvalid;
        logic [BYTE_W-1:0]                rdata;
    } store_st_t;

    store_st_t st_d, st_q;

    logic [N_ENTRIES-1:0]             wr_mask;
    logic [N_ENTRIES-1:0][BYTE_W-1:0] rst_img;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        assign wr_mask[g] = entry_writable(8'(g));
        assign rst_img[g] = entry_default(8'(g));
    end

    logic wr_ok;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        wr_ok       = wr_mask[st_q.ptr] && value_permitted(8'(st_q.ptr), wdata);
        if (ptr_we) begin
            st_d.ptr = IDX_W'(wdata);
        end
        if (data_we && wr_ok) begin
            st_d.mem[st_q.ptr] = wdata;
        end
        if (data_re) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = st_q.mem[st_q.ptr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem    <= rst_img;
            st_q.ptr    <= '0;
            st_q.rvalid <= 1'b0;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rdata;

    p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |=> $stable(st_q.ptr));

    p_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !wr_mask[st_q.ptr]) |=> $stable(st_q.mem));

    p_locked_e7_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mem[8'hE7] == 8'hFE);

    p_locked_e8_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mem[8'hE8] == 8'hBE);

    p_no_write_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> $stable(st_q.mem));

endmodule

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
    parameter logic [7:0]        EN_OFFSET = 8'h85,
    parameter int                EN_BIT    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [7:0]        io_rdata,
    output logic              io_rvalid,
    input  logic              host_cfg_we,
    input  logic [7:0]        host_cfg_off,
    input  logic [7:0]        host_cfg_wdata
);

    logic       ptr_we, data_we, data_re, win_on;
    logic       st_rvalid;
    logic [7:0] st_rdata;

    cfgw_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .EN_OFFSET (EN_OFFSET),
        .EN_BIT    (EN_BIT)
    ) i_decode (
        .clk            (clk),
        .rst_n          (rst_n),
        .io_addr        (io_addr),
        .io_rd          (io_rd),
        .io_wr          (io_wr),
        .host_cfg_we    (host_cfg_we),
        .host_cfg_off   (host_cfg_off),
        .host_cfg_wdata (host_cfg_wdata),
        .ptr_we         (ptr_we),
        .data_we        (data_we),
        .data_re        (data_re),
        .win_on         (win_on)
    );

    cfgw_store #(
        .IDX_W (8)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_we  (ptr_we),
        .data_we (data_we),
        .data_re (data_re),
        .wdata   (io_wdata),
        .rvalid  (st_rvalid),
        .rdata   (st_rdata)
    );

    assign io_rvalid = st_rvalid;
    assign io_rdata  = st_rvalid ? st_rdata : 8'hFF;

    p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && win_on && io_addr == BASE_ADDR + 1'b1) |=> io_rvalid);

    p_rvalid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> !io_rvalid);

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_on |=> (!io_rvalid && io_rdata == 8'hFF));

    p_base_read_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == BASE_ADDR) |=> !io_rvalid);

endmodule

// File: tb/test_cfg_window_ctrl.sv
module test_cfg_window_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic        host_cfg_we = 1'b0;
    logic [7:0]  host_cfg_off = '0;
    logic [7:0]  host_cfg_wdata = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_window_ctrl i_cfg_window_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .io_addr        (io_addr),
        .io_wdata       (io_wdata),
        .io_rd          (io_rd),
        .io_wr          (io_wr),
        .io_rdata       (io_rdata),
        .io_rvalid      (io_rvalid),
        .host_cfg_we    (host_cfg_we),
        .host_cfg_off   (host_cfg_off),
        .host_cfg_wdata (host_cfg_wdata)
    );

    localparam logic [1:0]  K_W  = 2'd1;
    localparam logic [1:0]  K_R  = 2'd2;
    localparam logic [15:0] A_IX = 16'h03F0;
    localparam logic [15:0] A_DT = 16'h03F1;
    localparam int NV = 30;

    // {req number, kind, address, data-or-expected}
    localparam logic [29:0] VEC [NV] = '{
        {4'd8, K_W, A_IX, 8'hE0}, {4'd8, K_W, A_DT, 8'h55}, {4'd8, K_R, A_DT, 8'h55},
        {4'd4, K_W, A_IX, 8'hE7}, {4'd4, K_W, A_DT, 8'h12}, {4'd4, K_R, A_DT, 8'hFE},
        {4'd4, K_W, A_DT, 8'hFE}, {4'd4, K_R, A_DT, 8'hFE},
        {4'd4, K_W, A_IX, 8'hE8}, {4'd4, K_W, A_DT, 8'h00}, {4'd4, K_R, A_DT, 8'hBE},
        {4'd3, K_W, A_IX, 8'hE4}, {4'd3, K_W, A_DT, 8'hAA}, {4'd3, K_R, A_DT, 8'h00},
        {4'd3, K_W, A_IX, 8'h10}, {4'd3, K_W, A_DT, 8'h77}, {4'd3, K_R, A_DT, 8'h00},
        {4'd8, K_W, A_IX, 8'hF0}, {4'd8, K_W, A_DT, 8'hC3}, {4'd8, K_R, A_DT, 8'hC3},
        {4'd3, K_W, A_IX, 8'hFF}, {4'd3, K_W, A_DT, 8'h11}, {4'd3, K_R, A_DT, 8'h00},
        {4'd8, K_W, A_IX, 8'hFC}, {4'd8, K_W, A_DT, 8'h99}, {4'd8, K_R, A_DT, 8'h99},
        {4'd3, K_W, A_IX, 8'hF9}, {4'd3, K_W, A_DT, 8'h33}, {4'd3, K_R, A_DT, 8'h00},
        {4'd8, K_R, A_DT, 8'h00}
    };

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // Read with expected data; exp_valid=0 means no pulse and 0xFF expected.
    task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input bit exp_valid, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check(io_rvalid == exp_valid, {req, " rvalid"}, {7'd0, io_rvalid}, {7'd0, exp_valid});
        check(io_rdata == (exp_valid ? exp : 8'hFF), {req, " rdata"}, io_rdata, exp_valid ? exp : 8'hFF);
        @(negedge clk);
        check(io_rvalid == 1'b0 && io_rdata == 8'hFF, {req, " pulse end R2"}, io_rdata, 8'hFF);
    endtask

    task automatic host_write(input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        host_cfg_we = 1'b1; host_cfg_off = off; host_cfg_wdata = d;
        @(negedge clk);
        host_cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(io_rvalid == 1'b0 && io_rdata == 8'hFF, "R2 reset output", io_rdata, 8'hFF);

        // R7 / R6: window off after reset; accesses are dropped
        io_read(A_DT, 8'h00, 1'b0, "R7 read while off");
        io_write(A_IX, 8'hE0);
        io_write(A_DT, 8'hAA);
        host_write(8'h84, 8'h02);            // wrong offset, R6
        io_read(A_DT, 8'h00, 1'b0, "R6 other offset ignored");
        host_write(8'h85, 8'h02);            // bit 1 set: on
        io_read(A_DT, 8'h00, 1'b1, "R7 pointer untouched while off");

        // R5 reset defaults
        io_write(A_IX, 8'hE0); io_read(A_DT, 8'h3C, 1'b1, "R5 E0 (R7 write dropped)");
        io_write(A_IX, 8'hE1); io_read(A_DT, 8'h00, 1'b1, "R5 E1");
        io_write(A_IX, 8'hE2); io_read(A_DT, 8'h03, 1'b1, "R5 E2");
        io_write(A_IX, 8'hE3); io_read(A_DT, 8'hFC, 1'b1, "R5 E3");
        io_write(A_IX, 8'hE6); io_read(A_DT, 8'hDE, 1'b1, "R5 E6");
        io_write(A_IX, 8'hE7); io_read(A_DT, 8'hFE, 1'b1, "R5 E7");
        io_write(A_IX, 8'hE8); io_read(A_DT, 8'hBE, 1'b1, "R5 E8");
        io_write(A_IX, 8'hEE); io_read(A_DT, 8'h00, 1'b1, "R5 EE");

        // Table walk: R1 R2 R3 R4 R8
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [1:0]  kd;
            logic [15:0] ad;
            logic [7:0]  dt;
            string       tag;
            {rq, kd, ad, dt} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            if (kd == K_W) io_write(ad, dt);
            else           io_read(ad, dt, 1'b1, tag);
        end

        // R9: outside addresses and base-address read
        io_write(A_IX, 8'hF1);
        io_write(A_DT, 8'h5A);
        io_write(16'h03F2, 8'hE0);
        io_write(16'h03EF, 8'h00);
        io_read(16'h03F0, 8'h00, 1'b0, "R9 base read silent");
        io_read(16'h13F1, 8'h00, 1'b0, "R9 aliased read silent");
        io_read(A_DT, 8'h5A, 1'b1, "R9 pointer and entry kept (R1)");

        // R6 turn off via bit 1 clear, then R7 write dropped
        host_write(8'h85, 8'hFD);
        io_read(A_DT, 8'h00, 1'b0, "R6 window off");
        io_write(A_DT, 8'h01);
        host_write(8'h85, 8'h02);
        io_read(A_DT, 8'h5A, 1'b1, "R7 entry kept while off");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule